// File: doc/BRIEF.md
# Boot and Run-Control Sequencer

This block is the top-level controller of a small 8-bit processor. It decides how the system starts and whether the core runs. While reset is held, two strap pins are sampled to pick one of three start modes. In the first mode the block waits for a debugger. In the second it takes a program passively as an SPI slave. In the third it reads the program itself from an external SPI flash, acting as the SPI master. A load fills the instruction memory with 256 16-bit words through a plain write port. In the two standalone modes the core is then released to run from address 0.

A debugger that runs on its own, much slower clock controls the core with five commands: reset, load, start, single-step and stop. Each command is carried across the clock boundary by a toggle handshake before it acts. The block has no knowledge of the core itself. It drives a run enable and a step enable to a separate instruction sequencer. It receives back a retire pulse for each instruction and a pulse when the core halts itself. It also tells the debugger when it may access internal state, which is only while the core is not running.

Top module: `boot_ctrl`

## Requirements
- R1: While `rst_n` is low, `strap` is sampled. 2'b01 selects the SPI-slave load, 2'b10 selects the SPI-flash load, and 2'b00 or 2'b11 selects the debugger-wait mode. A load mode starts loading as soon as reset is released. Debugger-wait mode shows the waiting status.
- R2: A load takes exactly 512 bytes and pairs them into words, the first byte of each pair being bits 15:8. Each word is written with a one-cycle `im_we` pulse. Addresses run 0, 1, … 255 in increasing order, and exactly 256 writes occur.
- R3: In SPI-slave loading, `ss_mosi` is sampled MSB first on each rising edge of `ss_sclk` while `ss_cs_n` is low (SPI mode 0). It is ignored outside the loading states.
- R4: In SPI-flash loading, the block pulls `fl_cs_n` low. It shifts out read command 0x03 and a 24-bit zero address MSB first on `fl_mosi`, changing data while `fl_sclk` is low. It then clocks in 4096 bits on `fl_miso` at rising edges. After that it raises `fl_cs_n` with `fl_sclk` low, for a total of 4128 rising clock edges.
- R5: At the end of a load, `load_done` goes to 1. The state becomes running if the strap mode is a standalone load, and stopped if the strap mode is debugger-wait.
- R6: A command is given by holding `dbg_cmd` steady and toggling `dbg_req`. It changes the state on the third rising `clk` edge after the toggle and not before. The codes are 1 RESET, 2 LOAD, 3 START, 4 STEP and 5 STOP.
- R7: START, given while waiting or stopped, raises `run_en` and the running status. STOP, given while running, drops `run_en` and shows the stopped status.
- R8: STEP, given while waiting or stopped, raises `step_en` alone until `insn_done` arrives. The block then shows the stopped status and drives `step_done` high for exactly one cycle.
- R9: A `seq_halt` pulse while running moves the block to stopped. In any other state `seq_halt` has no effect.
- R10: A command that is illegal in the current state leaves the state unchanged and sets the sticky `cmd_err`. The illegal cases are STEP, START or LOAD while running or loading, STOP when not running, any non-RESET command while stepping, and codes 0, 6 and 7. Only RESET clears `cmd_err`. RESET is legal in every state and returns the block to waiting.
- R11: `dbg_acc_ok` is high only when the synchronised `dbg_acc_req` is high and the state is waiting or stopped.
- R12: `st_state` encodes 0 waiting, 1 loading, 2 running or stepping, and 3 stopped. `core_reset` is high exactly while waiting or loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; strap sampled while low |
| strap | input | 2 | Start-mode strap pins |
| dbg_req | input | 1 | Debugger command toggle |
| dbg_cmd | input | 3 | Debugger command code, held steady around a toggle |
| dbg_acc_req | input | 1 | Debugger asks to access internal state (asynchronous level) |
| dbg_acc_ok | output | 1 | Access permitted (core not running) |
| ss_sclk | input | 1 | SPI-slave clock from an external host |
| ss_cs_n | input | 1 | SPI-slave select, active low |
| ss_mosi | input | 1 | SPI-slave data in |
| fl_sclk | output | 1 | SPI clock to the flash |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_mosi | output | 1 | Data to the flash |
| fl_miso | input | 1 | Data from the flash |
| im_we | output | 1 | Instruction memory write strobe |
| im_addr | output | 8 | Instruction memory word address |
| im_wdata | output | 16 | Instruction memory write data |
| run_en | output | 1 | Free-run enable to the instruction sequencer |
| step_en | output | 1 | Single-instruction enable to the instruction sequencer |
| core_reset | output | 1 | Holds the core in reset |
| insn_done | input | 1 | Sequencer pulse: one instruction retired |
| seq_halt | input | 1 | Sequencer pulse: core halted itself |
| st_state | output | 2 | Status code of the current state |
| load_done | output | 1 | Last load completed |
| cmd_err | output | 1 | Sticky illegal-command flag |
| step_done | output | 1 | One-cycle pulse when a single step ends |

## Verification
The load path is run three times: a debugger-ordered SPI-slave load, a strapped SPI-slave boot and a strapped flash boot. Each uses a different byte pattern in which every byte position differs. This shows up swapped halves, shifted addresses and misordered bits, and the three runs also separate the final stopped state from the final running state. Commands are sent in legal and illegal orders. Each order shows whether state changes, the sticky error and the single-step pulse happen together or apart. One command is sampled cycle by cycle to pin down the synchroniser latency. `seq_halt` is given both while running and while stopped, which shows that it acts only while running.

// File: rtl/boot_ctrl_pkg.sv
package boot_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_WAIT, ST_LOAD_SLV, ST_LOAD_FL, ST_RUN, ST_STEP, ST_STOP
  } ctl_state_e;

  typedef enum logic [1:0] {BM_DEBUG, BM_SLAVE, BM_FLASH} boot_mode_e;

  localparam logic [2:0] CMD_RESET = 3'd1;
  localparam logic [2:0] CMD_LOAD  = 3'd2;
  localparam logic [2:0] CMD_START = 3'd3;
  localparam logic [2:0] CMD_STEP  = 3'd4;
  localparam logic [2:0] CMD_STOP  = 3'd5;

  function automatic boot_mode_e strap_to_mode(input logic [1:0] s);
    case (s)
      2'b01:   return BM_SLAVE;
      2'b10:   return BM_FLASH;
      default: return BM_DEBUG;
    endcase
  endfunction

  function automatic ctl_state_e mode_entry(input boot_mode_e m);
    case (m)
      BM_SLAVE: return ST_LOAD_SLV;
      BM_FLASH: return ST_LOAD_FL;
      default:  return ST_WAIT;
    endcase
  endfunction

  function automatic logic [1:0] status_code(input ctl_state_e s);
    case (s)
      ST_WAIT:                 return 2'd0;
      ST_LOAD_SLV, ST_LOAD_FL: return 2'd1;
      ST_RUN, ST_STEP:         return 2'd2;
      default:                 return 2'd3;
    endcase
  endfunction

  function automatic logic cmd_legal(input logic [2:0] c, input ctl_state_e s);
    logic idle;
    idle = (s == ST_WAIT) || (s == ST_STOP);
    case (c)
      CMD_RESET:                     return 1'b1;
      CMD_LOAD, CMD_START, CMD_STEP: return idle;
      CMD_STOP:                      return s == ST_RUN;
      default:                       return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/boot_cmd_sync.sv
module boot_cmd_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbg_req,
  input  logic [2:0] dbg_cmd,
  input  logic       dbg_acc_req,
  output logic       cmd_fire,
  output logic [2:0] cmd_code,
  output logic       acc_req_s
);
  logic [2:0] tg_q;
  logic [1:0] acc_q;

  // During reset the toggle chain follows the pin, so no stale command fires.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tg_q  <= {3{dbg_req}};
      acc_q <= 2'b00;
    end else begin
      tg_q  <= {tg_q[1:0], dbg_req};
      acc_q <= {acc_q[0], dbg_acc_req};
    end
  end

  assign cmd_fire  = tg_q[1] ^ tg_q[2];
  assign cmd_code  = dbg_cmd;   // held steady by the debugger around the toggle
  assign acc_req_s = acc_q[1];

  assert_fire_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire);
endmodule

// File: rtl/boot_spi_rx.sv
module boot_spi_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ss_sclk,
  input  logic       ss_cs_n,
  input  logic       ss_mosi,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  logic [2:0] sclk_s;
  logic [1:0] cs_s, mosi_s;
  logic [2:0] bit_q;
  logic [6:0] sh_q;
  logic       sclk_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_s <= 3'b000;
      cs_s   <= 2'b11;
      mosi_s <= 2'b00;
    end else begin
      sclk_s <= {sclk_s[1:0], ss_sclk};
      cs_s   <= {cs_s[0], ss_cs_n};
      mosi_s <= {mosi_s[0], ss_mosi};
    end
  end

  assign sclk_rise = sclk_s[1] & ~sclk_s[2];

  always_ff @(posedge clk) begin
    byte_vld <= 1'b0;
    if (!rst_n || !en || cs_s[1]) begin
      bit_q <= '0;
      sh_q  <= '0;
    end else if (sclk_rise) begin
      sh_q  <= {sh_q[5:0], mosi_s[1]};
      bit_q <= bit_q + 1'b1;
      if (bit_q == 3'd7) begin
        byte_vld <= 1'b1;
        byte_q   <= {sh_q, mosi_s[1]};
      end
    end
  end

  assert_rx_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(en));
endmodule

// File: rtl/boot_flash_rd.sv
module boot_flash_rd #(
  parameter int          NBYTES = 512,
  parameter int          HALF   = 2,
  parameter logic [7:0]  RD_CMD = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  output logic       fl_sclk,
  output logic       fl_cs_n,
  output logic       fl_mosi,
  input  logic       fl_miso,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  localparam int HDR   = 32;
  localparam int TOTAL = HDR + 8 * NBYTES;
  localparam int BW    = $clog2(TOTAL + 1);
  localparam int DW    = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active_q, finished_q, sclk_q, cs_q;
  logic [DW-1:0] div_q;
  logic [BW-1:0] bits_q;
  logic [31:0]   out_q;
  logic [6:0]    in_q;

  always_ff @(posedge clk) begin
    byte_vld <= 1'b0;
    if (!rst_n || !en) begin
      active_q   <= 1'b0;
      finished_q <= 1'b0;
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      div_q      <= '0;
      bits_q     <= '0;
      out_q      <= '0;
      in_q       <= '0;
    end else if (!active_q) begin
      if (!finished_q) begin
        active_q <= 1'b1;
        cs_q     <= 1'b0;
        out_q    <= {RD_CMD, 24'h000000};
        bits_q   <= '0;
        div_q    <= '0;
      end
    end else if (div_q == DW'(HALF - 1)) begin
      div_q <= '0;
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        if (bits_q >= BW'(HDR)) begin
          in_q <= {in_q[5:0], fl_miso};
          if (bits_q[2:0] == 3'd7) begin
            byte_vld <= 1'b1;
            byte_q   <= {in_q, fl_miso};
          end
        end
      end else begin
        sclk_q <= 1'b0;
        out_q  <= {out_q[30:0], 1'b0};
        bits_q <= bits_q + 1'b1;
        if (bits_q == BW'(TOTAL - 1)) begin
          active_q   <= 1'b0;
          finished_q <= 1'b1;
          cs_q       <= 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign fl_sclk = sclk_q;
  assign fl_cs_n = cs_q;
  assign fl_mosi = out_q[31];

  assert_clk_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cs_n |-> !fl_sclk);
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_ctrl_pkg::*;
#(
  parameter int NBYTES  = 512,
  parameter int FL_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  strap,
  input  logic        dbg_req,
  input  logic [2:0]  dbg_cmd,
  input  logic        dbg_acc_req,
  output logic        dbg_acc_ok,
  input  logic        ss_sclk,
  input  logic        ss_cs_n,
  input  logic        ss_mosi,
  output logic        fl_sclk,
  output logic        fl_cs_n,
  output logic        fl_mosi,
  input  logic        fl_miso,
  output logic        im_we,
  output logic [7:0]  im_addr,
  output logic [15:0] im_wdata,
  output logic        run_en,
  output logic        step_en,
  output logic        core_reset,
  input  logic        insn_done,
  input  logic        seq_halt,
  output logic [1:0]  st_state,
  output logic        load_done,
  output logic        cmd_err,
  output logic        step_done
);
  localparam int CW = $clog2(NBYTES);

  ctl_state_e state_q, state_d;
  boot_mode_e mode_q;
  logic       cmd_fire, acc_req_s, cmd_ok, rst_accept;
  logic [2:0] cmd_code;
  logic       ld_active, s_vld, f_vld, byte_vld, last_byte;
  logic [7:0] s_byte, f_byte, byte_in, hi_q;
  logic [CW-1:0] cnt_q;

  boot_cmd_sync u_sync (
    .clk, .rst_n, .dbg_req, .dbg_cmd, .dbg_acc_req,
    .cmd_fire, .cmd_code, .acc_req_s
  );

  boot_spi_rx u_rx (
    .clk, .rst_n, .en(state_q == ST_LOAD_SLV),
    .ss_sclk, .ss_cs_n, .ss_mosi,
    .byte_vld(s_vld), .byte_q(s_byte)
  );

  boot_flash_rd #(.NBYTES(NBYTES), .HALF(FL_HALF)) u_fl (
    .clk, .rst_n, .en(state_q == ST_LOAD_FL),
    .fl_sclk, .fl_cs_n, .fl_mosi, .fl_miso,
    .byte_vld(f_vld), .byte_q(f_byte)
  );

  // Named internal events
  assign ld_active  = (state_q == ST_LOAD_SLV) || (state_q == ST_LOAD_FL);
  assign byte_vld   = (state_q == ST_LOAD_SLV) ? s_vld : (state_q == ST_LOAD_FL) & f_vld;
  assign byte_in    = (state_q == ST_LOAD_SLV) ? s_byte : f_byte;
  assign last_byte  = ld_active && byte_vld && (cnt_q == CW'(NBYTES - 1));
  assign cmd_ok     = cmd_fire && cmd_legal(cmd_code, state_q);
  assign rst_accept = cmd_ok && (cmd_code == CMD_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= strap_to_mode(strap);
  end

  always_comb begin
    state_d = state_q;
    if (cmd_ok) begin
      case (cmd_code)
        CMD_LOAD:  state_d = (mode_q == BM_FLASH) ? ST_LOAD_FL : ST_LOAD_SLV;
        CMD_START: state_d = ST_RUN;
        CMD_STEP:  state_d = ST_STEP;
        CMD_STOP:  state_d = ST_STOP;
        default:   state_d = ST_WAIT;
      endcase
    end else begin
      case (state_q)
        ST_LOAD_SLV, ST_LOAD_FL:
          if (last_byte) state_d = (mode_q == BM_DEBUG) ? ST_STOP : ST_RUN;
        ST_RUN:  if (seq_halt)  state_d = ST_STOP;
        ST_STEP: if (insn_done) state_d = ST_STOP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= mode_entry(strap_to_mode(strap));
      cmd_err   <= 1'b0;
      load_done <= 1'b0;
      step_done <= 1'b0;
    end else begin
      state_q   <= state_d;
      step_done <= (state_q == ST_STEP) && insn_done && !cmd_ok;
      if (rst_accept)                cmd_err <= 1'b0;
      else if (cmd_fire && !cmd_ok)  cmd_err <= 1'b1;
      if (rst_accept || (cmd_ok && cmd_code == CMD_LOAD)) load_done <= 1'b0;
      else if (last_byte && !cmd_ok)                      load_done <= 1'b1;
    end
  end

  // Byte pairing and write port
  always_ff @(posedge clk) begin
    im_we <= 1'b0;
    if (!rst_n || !ld_active) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else if (byte_vld) begin
      cnt_q <= cnt_q + 1'b1;
      if (!cnt_q[0]) begin
        hi_q <= byte_in;
      end else begin
        im_we    <= 1'b1;
        im_addr  <= cnt_q[CW-1:1];
        im_wdata <= {hi_q, byte_in};
      end
    end
  end

  assign run_en     = state_q == ST_RUN;
  assign step_en    = state_q == ST_STEP;
  assign core_reset = (state_q == ST_WAIT) || ld_active;
  assign st_state   = status_code(state_q);
  assign dbg_acc_ok = acc_req_s && ((state_q == ST_WAIT) || (state_q == ST_STOP));

  assert_write_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    im_we |-> $past(ld_active));
  assert_step_done_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (st_state == 2'd3) && $past(step_en));
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_err) && !$past(rst_accept)) |-> cmd_err);
  assert_access_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_acc_ok |-> (st_state == 2'd0 || st_state == 2'd3));
  assert_held_not_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> !run_en && !step_en);
endmodule

// File: tb/tb_boot_ctrl.sv
module tb_boot_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] strap = 2'b00;
  logic dbg_req = 1'b0, dbg_acc_req = 1'b0;
  logic [2:0] dbg_cmd = 3'd0;
  logic dbg_acc_ok;
  logic ss_sclk = 1'b0, ss_cs_n = 1'b1, ss_mosi = 1'b0;
  logic fl_sclk, fl_cs_n, fl_mosi;
  logic fl_miso = 1'b0;
  logic im_we;
  logic [7:0] im_addr;
  logic [15:0] im_wdata;
  logic run_en, step_en, core_reset, load_done, cmd_err, step_done;
  logic insn_done = 1'b0, seq_halt = 1'b0;
  logic [1:0] st_state;

  int checks = 0, fails = 0;
  logic cap_clr = 1'b0;
  logic [15:0] mem [256];
  int wr_cnt, ord_err, exp_addr, sd_cnt;
  int rcnt = 0;
  logic [31:0] cmdsh = 0;

  always #5 clk = ~clk;

  boot_ctrl dut (.*);

  // Capture of the instruction memory port and step pulses
  always @(posedge clk) begin
    if (cap_clr) begin
      wr_cnt = 0; ord_err = 0; exp_addr = 0; sd_cnt = 0;
    end else if (rst_n) begin
      if (im_we) begin
        if (32'(im_addr) != exp_addr) ord_err++;
        mem[im_addr] <= im_wdata;
        exp_addr++;
        wr_cnt++;
      end
      if (step_done) sd_cnt++;
    end
  end

  function automatic logic [7:0] sdat(input int k);
    return 8'(k * 29 + 7) ^ 8'(k >> 3);
  endfunction
  function automatic logic [7:0] fdat(input int k);
    return 8'(k * 53 + 100) ^ 8'(k >> 8);
  endfunction

  // Flash model: counts rising edges, records the header, serves data
  always @(posedge fl_sclk or negedge fl_cs_n) begin
    if (fl_sclk) begin
      if (!fl_cs_n) begin
        if (rcnt < 32) cmdsh = {cmdsh[30:0], fl_mosi};
        rcnt++;
      end
    end else begin
      rcnt = 0;
      cmdsh = 0;
    end
  end
  always @(negedge fl_sclk) begin
    if (!fl_cs_n && rcnt >= 32) begin
      automatic int idx = rcnt - 32;
      automatic logic [7:0] b = fdat(idx >> 3);
      fl_miso = b[7 - (idx & 7)];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst_n = 1'b0; strap = s; cap_clr = 1'b1;
    cyc(3);
    rst_n = 1'b1; cap_clr = 1'b0; strap = 2'b00;
    cyc(1);
  endtask

  task automatic send_cmd(input logic [2:0] c);
    dbg_cmd = c;
    cyc(2);
    dbg_req = ~dbg_req;
    cyc(6);
  endtask

  task automatic send_slave(input int n);
    ss_cs_n = 1'b0;
    cyc(4);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        automatic logic [7:0] v = sdat(k);
        ss_mosi = v[b];
        cyc(4); ss_sclk = 1'b1;
        cyc(4); ss_sclk = 1'b0;
      end
    end
    cyc(4);
    ss_cs_n = 1'b1;
    cyc(8);
  endtask

  task automatic check_mem(input string tag, input bit flash);
    int bad = 0;
    logic [15:0] e, a;
    for (int w = 0; w < 256; w++) begin
      logic [15:0] x;
      x = flash ? {fdat(2 * w), fdat(2 * w + 1)} : {sdat(2 * w), sdat(2 * w + 1)};
      if (mem[w] !== x && bad == 0) begin e = x; a = mem[w]; end
      if (mem[w] !== x) bad++;
    end
    if (bad != 0) chk(tag, 32'(a), 32'(e)); else chk(tag, 0, 0);
    chk({tag, " write count"}, wr_cnt, 256);
    chk({tag, " address order"}, ord_err, 0);
  endtask

  task automatic t_reset_debug();
    do_reset(2'b00);
    chk("R1 debug strap waiting", st_state, 0);
    chk("R12 core_reset while waiting", core_reset, 1);
    chk("R12 run_en idle", {run_en, step_en}, 0);
    chk("R5 load_done reset", load_done, 0);
    chk("R10 cmd_err reset", cmd_err, 0);
  endtask

  task automatic t_illegal();
    send_cmd(3'd5);
    chk("R10 STOP in wait ignored", st_state, 0);
    chk("R10 STOP in wait sets err", cmd_err, 1);
    send_cmd(3'd7);
    chk("R10 bad code ignored", st_state, 0);
    send_cmd(3'd1);
    chk("R10 RESET clears err", cmd_err, 0);
    dbg_acc_req = 1'b1; cyc(4);
    chk("R11 access granted while waiting", dbg_acc_ok, 1);
  endtask

  task automatic t_start_stop();
    send_cmd(3'd3);
    chk("R7 START runs", {st_state, run_en}, {2'd2, 1'b1});
    chk("R12 core released", core_reset, 0);
    chk("R11 access refused while running", dbg_acc_ok, 0);
    send_cmd(3'd4);
    chk("R10 STEP while running ignored", {st_state, step_en}, {2'd2, 1'b0});
    chk("R10 STEP while running sets err", cmd_err, 1);
    send_cmd(3'd5);
    chk("R7 STOP stops", {st_state, run_en}, {2'd3, 1'b0});
    chk("R10 err sticky", cmd_err, 1);
    chk("R11 access granted when stopped", dbg_acc_ok, 1);
    dbg_acc_req = 1'b0;
    send_cmd(3'd1);
    chk("R10 RESET returns to wait", {st_state, core_reset, cmd_err}, {2'd0, 1'b1, 1'b0});
  endtask

  task automatic t_step();
    send_cmd(3'd4);
    chk("R8 STEP enables one", {st_state, step_en, run_en}, {2'd2, 1'b1, 1'b0});
    cyc(5);
    chk("R8 step holds until retire", step_en, 1);
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    chk("R8 stopped after retire", {st_state, step_en, step_done}, {2'd3, 1'b0, 1'b1});
    cyc(1);
    chk("R8 step_done one cycle", step_done, 0);
    cyc(3);
    chk("R8 step_done pulse count", sd_cnt, 1);
    chk("R8 step legal no err", cmd_err, 0);
  endtask

  task automatic t_halt();
    send_cmd(3'd3);
    seq_halt = 1'b1; cyc(1); seq_halt = 1'b0;
    chk("R9 halt while running stops", {st_state, run_en}, {2'd3, 1'b0});
    seq_halt = 1'b1; cyc(1); seq_halt = 1'b0; cyc(2);
    chk("R9 halt while stopped no effect", {st_state, cmd_err}, {2'd3, 1'b0});
  endtask

  task automatic t_sync_latency();
    dbg_cmd = 3'd3; cyc(2);
    dbg_req = ~dbg_req;
    cyc(2);
    chk("R6 no effect before third edge", st_state, 3);
    cyc(1);
    chk("R6 START on third edge", st_state, 2);
    send_cmd(3'd5);
  endtask

  task automatic t_dbg_load();
    cap_clr = 1'b1; cyc(1); cap_clr = 1'b0;
    ss_mosi = 1'b1; ss_sclk = 1'b1; cyc(6); ss_sclk = 1'b0; cyc(6);
    send_cmd(3'd2);
    chk("R12 loading status", {st_state, core_reset}, {2'd1, 1'b1});
    chk("R3 no write from idle toggles", wr_cnt, 0);
    send_slave(512);
    chk("R5 debug load ends stopped", {st_state, load_done, run_en}, {2'd3, 1'b1, 1'b0});
    check_mem("R2 R3 debug slave load", 1'b0);
  endtask

  task automatic t_slave_boot();
    do_reset(2'b01);
    chk("R1 slave strap loads", {st_state, core_reset}, {2'd1, 1'b1});
    send_slave(510);
    chk("R2 not done before 512 bytes", {st_state, load_done}, {2'd1, 1'b0});
    send_slave(0);
    do_reset(2'b01);
    send_slave(512);
    chk("R5 slave boot runs", {st_state, run_en, load_done}, {2'd2, 1'b1, 1'b1});
    check_mem("R2 R3 slave boot", 1'b0);
  endtask

  task automatic t_flash_boot();
    do_reset(2'b10);
    chk("R1 flash strap loads", st_state, 1);
    for (int i = 0; i < 30000 && st_state == 2'd1; i++) cyc(1);
    cyc(2);
    chk("R4 read command and address", cmdsh, 32'h0300_0000);
    chk("R4 rising edge count", rcnt, 4128);
    chk("R4 chip select released idle", {fl_cs_n, fl_sclk}, {1'b1, 1'b0});
    chk("R5 flash boot runs", {st_state, run_en, load_done}, {2'd2, 1'b1, 1'b1});
    check_mem("R2 R4 flash boot", 1'b1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_debug();
    t_illegal();
    t_start_stop();
    t_step();
    t_halt();
    t_sync_latency();
    t_dbg_load();
    t_slave_boot();
    t_flash_boot();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule